// File: doc/BRIEF.md
# Lane Access Coalescer

The block takes one memory instruction issued by sixteen parallel lanes and turns it into the smallest practical series of aligned memory transactions. Each lane supplies an enable bit and a byte address; the instruction carries one element width shared by all lanes. The block works through the lanes repeatedly. On each pass it takes the lowest-numbered lane that still needs service and opens the aligned segment holding that lane's address. Every other pending lane whose address falls in that segment joins the same transaction. The transaction is then narrowed as far as the grouped addresses allow, and the lanes it covers are retired.

A mode input selects a stricter ordering rule. Under this rule, the active lanes must form one in-order run: lane k touches element k of a single segment. If they do, the result is the same as in grouping mode. If they do not, the block gives up coalescing and issues one 32-byte transaction per active lane.

Requests enter through a valid/ready handshake. Transactions leave one per cycle through a second valid/ready handshake. The block holds one request at a time.

Top module: `lane_coalescer`

## Requirements
- R1: After reset, txValid is low and reqReady is high.
- R2: reqReady is low from the cycle after a request with at least one active lane is accepted until the cycle after its last transaction is handshaked. While reqReady is low, txValid is high.
- R3: A request whose reqActive is all zeros is accepted and produces no transaction. reqReady stays high in the following cycle.
- R4: Each transaction is led by the lowest-numbered lane not yet serviced. Transactions therefore come out in ascending order of their lowest lane.
- R5: The segment width depends on reqElemSize. Code 0 (1-byte elements) gives 32 bytes, code 1 (2-byte) gives 64 bytes, and code 2 (4-byte) gives 128 bytes. Code 3 is treated as code 2. txSize encodes 0 as 32 bytes, 1 as 64 bytes and 2 as 128 bytes.
- R6: txMask holds exactly those pending lanes whose address lies in the same aligned segment as the leading lane.
- R7: Narrowing rule for a 128-byte segment: if all grouped addresses lie in one 64-byte half, the transaction is 64 bytes. Narrowing rule for a 64-byte segment or transaction: if all grouped addresses lie in one 32-byte half, the transaction is 32 bytes.
- R8: txBase is the leading lane's address rounded down to a multiple of the transaction size.
- R9: Every active lane appears in exactly one transaction mask. Inactive lanes never appear.
- R10: In strict mode (strictMode=1), the lanes pass the check when every active lane k has address S + k*E. Here E is the element width in bytes and S is the leading lane's address rounded down to the segment width. A request that passes yields the same transactions as grouping mode.
- R11: In strict mode, a request that fails the check yields one transaction per active lane, in ascending lane order. Each of these transactions is 32 bytes at the lane's address rounded down to 32.
- R12: While txValid is high and txReady is low, txBase, txSize and txMask hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken |
| reqActive | input | 16 | Per-lane enable |
| reqAddr | input | 512 | Lane byte addresses, lane i at bits [32*i+31:32*i] |
| reqElemSize | input | 2 | Element width code |
| strictMode | input | 1 | 1 selects the in-order strict rule |
| txValid | output | 1 | Transaction offered |
| txReady | input | 1 | Transaction taken |
| txBase | output | 32 | Aligned transaction base address |
| txSize | output | 2 | Transaction size code |
| txMask | output | 16 | Lanes served by this transaction |

## Verification
The hardest case to reach is the narrowing chain. It needs a 128-byte segment whose members share one 64-byte half and then one 32-byte half, and it needs this together with lanes that are still pending outside the segment, so that later passes run. Random addresses almost never produce it. The stimulus therefore builds lane addresses from a random base, a small window size chosen per request (32, 64, 256 or 1024 bytes) and random offsets inside that window. This concentrates lanes into shared segments and halves while still scattering some of them. It mixes in strict-conforming runs, shuffled runs and partly active runs, and holds txReady low at random to exercise the hold rule.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    SIZE32  = 2'd0,
    SIZE64  = 2'd1,
    SIZE128 = 2'd2
  } txSizeE;

  typedef struct packed {
    logic load;
    logic retire;
  } ctrlStrobeT;

  function automatic logic [1:0] normElem(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobeT              strobe,
  input  logic [LANES-1:0]        inActive,
  input  logic [LANES*ADDR_W-1:0] inAddr,
  input  logic [1:0]              inElem,
  input  logic                    inStrict,
  output logic [ADDR_W-1:0]       txBase,
  output logic [1:0]              txSize,
  output logic [LANES-1:0]        txMask,
  output logic                    lastTx
);
  localparam int IDX_W = $clog2(LANES);
  localparam int MIN_SEG_BITS = 5;

  logic [ADDR_W-1:0] addrQ [LANES];
  logic [LANES-1:0]  pendQ;
  logic [1:0]        segCodeQ;
  logic              fallbackQ;

  // ---- strict-order check on the incoming request ----
  logic [1:0]        inSeg;
  logic [IDX_W-1:0]  inLead;
  logic [ADDR_W-1:0] inLeadAddr;
  logic [ADDR_W-1:0] inOffMask;
  logic [LANES-1:0]  laneOk;
  logic              strictOk;

  assign inSeg     = normElem(inElem);
  assign inOffMask = (ADDR_W'(32) << inSeg) - ADDR_W'(1);

  always_comb begin
    inLead = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (inActive[i]) inLead = IDX_W'(i);
    end
  end
  assign inLeadAddr = inAddr[inLead*ADDR_W +: ADDR_W];

  for (genvar g = 0; g < LANES; g++) begin : gStrict
    logic [ADDR_W-1:0] laneAddr;
    logic              sameSeg;
    logic              inPlace;
    assign laneAddr = inAddr[g*ADDR_W +: ADDR_W];
    assign sameSeg  = (((laneAddr ^ inLeadAddr) >> (MIN_SEG_BITS + int'(inSeg))) == '0);
    assign inPlace  = ((laneAddr & inOffMask) == (ADDR_W'(g) << inSeg));
    assign laneOk[g] = !inActive[g] || (sameSeg && inPlace);
  end
  assign strictOk = &laneOk;

  // ---- request storage ----
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ     <= '0;
      segCodeQ  <= '0;
      fallbackQ <= 1'b0;
    end else if (strobe.load) begin
      pendQ     <= inActive;
      segCodeQ  <= inSeg;
      fallbackQ <= inStrict && !strictOk;
    end else if (strobe.retire) begin
      pendQ     <= pendQ & ~txMask;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gAddr
    always_ff @(posedge clk) begin
      if (!rstN) addrQ[g] <= '0;
      else if (strobe.load) addrQ[g] <= inAddr[g*ADDR_W +: ADDR_W];
    end
  end

  // ---- transaction formation from stored state ----
  logic [IDX_W-1:0]  lead;
  logic [ADDR_W-1:0] leadAddr;
  logic [LANES-1:0]  member;
  logic [ADDR_W-1:0] diffOr;
  logic [1:0]        sizeCode;

  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pendQ[i]) lead = IDX_W'(i);
    end
  end
  assign leadAddr = addrQ[lead];

  for (genvar g = 0; g < LANES; g++) begin : gGroup
    logic inSegment;
    assign inSegment = (((addrQ[g] ^ leadAddr) >> (MIN_SEG_BITS + int'(segCodeQ))) == '0);
    assign member[g] = fallbackQ ? (pendQ[g] && (IDX_W'(g) == lead))
                                 : (pendQ[g] && inSegment);
  end

  always_comb begin
    diffOr = '0;
    for (int i = 0; i < LANES; i++) begin
      if (member[i]) diffOr = diffOr | (addrQ[i] ^ leadAddr);
    end
    sizeCode = segCodeQ;
    if (sizeCode == 2'd2 && !diffOr[6]) sizeCode = 2'd1;
    if (sizeCode == 2'd1 && !diffOr[5]) sizeCode = 2'd0;
  end

  assign txMask = member;
  assign txSize = sizeCode;
  assign txBase = leadAddr & ~((ADDR_W'(32) << sizeCode) - ADDR_W'(1));
  assign lastTx = ((pendQ & ~member) == '0);
endmodule

// File: rtl/coal_control.sv
module coal_control
  import coal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       anyActive,
  input  logic       txReady,
  input  logic       lastTx,
  output logic       reqReady,
  output logic       txValid,
  output ctrlStrobeT strobe
);
  typedef enum logic {ST_IDLE, ST_ISSUE} stateE;
  stateE state;

  logic accept;
  logic txFire;

  assign reqReady = (state == ST_IDLE);
  assign txValid  = (state == ST_ISSUE);
  assign accept   = reqValid && reqReady;
  assign txFire   = txValid && txReady;

  always_comb begin
    strobe        = '0;
    strobe.load   = accept;
    strobe.retire = txFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else begin
      case (state)
        ST_IDLE:  if (accept && anyActive) state <= ST_ISSUE;
        ST_ISSUE: if (txFire && lastTx) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_coalescer.sv
module lane_coalescer
  import coal_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [LANES-1:0]        reqActive,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [1:0]              reqElemSize,
  input  logic                    strictMode,
  output logic                    txValid,
  input  logic                    txReady,
  output logic [ADDR_W-1:0]       txBase,
  output logic [1:0]              txSize,
  output logic [LANES-1:0]        txMask
);
  ctrlStrobeT strobe;
  logic       lastTx;

  coal_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .anyActive(|reqActive),
    .txReady(txReady), .lastTx(lastTx), .reqReady(reqReady),
    .txValid(txValid), .strobe(strobe)
  );

  coal_datapath #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inActive(reqActive),
    .inAddr(reqAddr), .inElem(reqElemSize), .inStrict(strictMode),
    .txBase(txBase), .txSize(txSize), .txMask(txMask), .lastTx(lastTx)
  );
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [LANES-1:0]  reqActive,
  input logic              txValid,
  input logic              txReady,
  input logic [ADDR_W-1:0] txBase,
  input logic [1:0]        txSize,
  input logic [LANES-1:0]  txMask
);
  logic [LANES-1:0] remQ;
  always_ff @(posedge clk) begin
    if (!rstN) remQ <= '0;
    else if (reqValid && reqReady) remQ <= reqActive;
    else if (txValid && txReady) remQ <= remQ & ~txMask;
  end

  a_r2_one_side: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && txValid));
  a_r3_empty_req: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqActive == '0) |=> (reqReady && !txValid));
  a_r5_size_code: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txSize != 2'd3));
  a_r6_mask_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txMask != '0));
  a_r8_aligned: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> ((txBase & ((ADDR_W'(32) << txSize) - ADDR_W'(1))) == '0));
  a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> ((txMask & ~remQ) == '0));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txBase) && $stable(txSize) && $stable(txMask)));
endmodule

bind lane_coalescer coal_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) u_coal_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqActive(reqActive), .txValid(txValid), .txReady(txReady),
  .txBase(txBase), .txSize(txSize), .txMask(txMask)
);

// File: tb/lane_coalescer_tb_top.sv
module lane_coalescer_tb_top;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [LANES-1:0]  reqActive = '0;
  logic [LANES*AW-1:0] reqAddr = '0;
  logic [1:0]        reqElemSize = '0;
  logic              strictMode = 1'b0;
  logic              txValid;
  logic              txReady = 1'b0;
  logic [AW-1:0]     txBase;
  logic [1:0]        txSize;
  logic [LANES-1:0]  txMask;

  always #5 clk = ~clk;

  lane_coalescer #(.LANES(LANES), .ADDR_W(AW)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [31:0] aArr [LANES];
  logic [31:0] expBase [LANES];
  int          expSize [LANES];
  logic [15:0] expMask [LANES];
  int          expN;

  always @(posedge clk) cycles++;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Independent reference: segment bytes, membership by division, narrowing by halves.
  task automatic buildExpected(input logic [15:0] act, input int code, input bit strict);
    int e, segB, eb, lead, sz;
    logic [15:0] pend;
    bit fail;
    e = (code == 3) ? 2 : code;
    segB = 32 << e;
    eb = 1 << e;
    expN = 0;
    pend = act;
    fail = 0;
    if (strict && act != 0) begin
      lead = 0;
      for (int k = LANES - 1; k >= 0; k--) if (act[k]) lead = k;
      for (int k = 0; k < LANES; k++)
        if (act[k] && aArr[k] != (aArr[lead] - aArr[lead] % segB) + k * eb) fail = 1;
    end
    while (pend != 0) begin
      logic [15:0] m;
      lead = 0;
      for (int k = LANES - 1; k >= 0; k--) if (pend[k]) lead = k;
      m = 0;
      for (int k = 0; k < LANES; k++)
        if (pend[k] && (fail ? (k == lead) : (aArr[k] / segB == aArr[lead] / segB))) m[k] = 1'b1;
      sz = fail ? 32 : segB;
      while (sz > 32) begin
        bit same = 1;
        for (int k = 0; k < LANES; k++)
          if (m[k] && aArr[k] / (sz / 2) != aArr[lead] / (sz / 2)) same = 0;
        if (!same) break;
        sz = sz / 2;
      end
      expBase[expN] = aArr[lead] - aArr[lead] % sz;
      expSize[expN] = (sz == 32) ? 0 : (sz == 64) ? 1 : 2;
      expMask[expN] = m;
      expN++;
      pend = pend & ~m;
    end
  endtask

  task automatic runReq(input logic [15:0] act, input int code, input bit strict,
                        input string tag);
    int idx;
    int guard;
    buildExpected(act, code, strict);
    @(negedge clk);
    check(reqReady === 1'b1, "R2", "reqReady before request", reqReady, 1);
    reqValid = 1'b1;
    reqActive = act;
    reqElemSize = code[1:0];
    strictMode = strict;
    for (int k = 0; k < LANES; k++) reqAddr[k*AW +: AW] = aArr[k];
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    reqActive = $urandom;
    idx = 0;
    guard = 0;
    while (idx < expN && guard < 200) begin
      @(negedge clk);
      guard++;
      check(txValid === 1'b1 && reqReady === 1'b0, "R2", "busy handshake state",
            {txValid, reqReady}, 2'b10);
      // R4 R6 R7 R8 R10 R11 R12: field compare (repeats under backpressure check holding)
      check(txBase === expBase[idx], tag, "txBase", txBase, expBase[idx]);
      check(txSize === 2'(expSize[idx]), tag, "txSize", txSize, expSize[idx]);
      check(txMask === expMask[idx], tag, "txMask", txMask, expMask[idx]);
      txReady = ($urandom % 3) != 0;
      @(posedge clk);
      #1;
      if (txReady) idx++;
      txReady = 1'b0;
    end
    @(negedge clk);
    // R3 R9: after the last (or no) transaction the block is idle again
    check(txValid === 1'b0 && reqReady === 1'b1, "R9 R3", "idle after request",
          {txValid, reqReady}, 2'b01);
  endtask

  function automatic logic [31:0] randBase();
    return {$urandom} & 32'hFFFF_FC00;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    // R1: reset values
    check(txValid === 1'b0 && reqReady === 1'b1, "R1", "reset outputs",
          {txValid, reqReady}, 2'b01);
    rstN = 1'b1;
    @(negedge clk);
    check(txValid === 1'b0 && reqReady === 1'b1, "R1", "after reset release",
          {txValid, reqReady}, 2'b01);

    // R5 R7: 4-byte contiguous run in a 128 segment narrows to 64
    for (int k = 0; k < LANES; k++) aArr[k] = 32'h0000_1000 + k * 4;
    runReq(16'hFFFF, 2, 0, "R5 R7 contiguous-4B");
    // R5: 1-byte contiguous run -> one 32-byte transaction
    for (int k = 0; k < LANES; k++) aArr[k] = 32'h0000_2040 + k;
    runReq(16'hFFFF, 0, 0, "R5 contiguous-1B");
    // R5: code 3 behaves as 4-byte, spread across whole 128 segment
    for (int k = 0; k < LANES; k++) aArr[k] = 32'h0000_3000 + k * 8;
    runReq(16'hFFFF, 3, 0, "R5 code3");
    // R3: empty request
    runReq(16'h0000, 1, 0, "R3 empty");
    runReq(16'h0000, 2, 1, "R3 empty strict");
    // R4 R6: each lane in its own segment, only odd lanes active
    for (int k = 0; k < LANES; k++) aArr[k] = 32'h0001_0000 + (LANES - k) * 256;
    runReq(16'hAAAA, 1, 0, "R4 R6 scattered");
    // R10: strict pass, partly active
    for (int k = 0; k < LANES; k++) aArr[k] = 32'h0000_5080 + k * 2;
    runReq(16'h0FF0, 1, 1, "R10 strict-pass");
    // R11: strict fail by swapping two lanes
    for (int k = 0; k < LANES; k++) aArr[k] = 32'h0000_6000 + k * 4;
    aArr[2] = 32'h0000_6000 + 3 * 4;
    aArr[3] = 32'h0000_6000 + 2 * 4;
    runReq(16'hFFFF, 2, 1, "R11 strict-fail");
    // R11: same pattern in grouping mode coalesces
    runReq(16'hFFFF, 2, 0, "R6 R7 swapped-flexible");

    // random mix
    for (int n = 0; n < 400 && cycles < 150000; n++) begin
      logic [31:0] b;
      int code, win, pat;
      logic [15:0] act;
      b = randBase();
      code = $urandom % 4;
      pat = $urandom % 4;
      case ($urandom % 4)
        0: win = 32;
        1: win = 64;
        2: win = 256;
        default: win = 1024;
      endcase
      for (int k = 0; k < LANES; k++) aArr[k] = b + ($urandom % win);
      if (pat == 0) begin
        int e = (code == 3) ? 2 : code;
        for (int k = 0; k < LANES; k++) aArr[k] = b + k * (1 << e);
      end else if (pat == 1) begin
        int e = (code == 3) ? 2 : code;
        int s = $urandom % LANES;
        for (int k = 0; k < LANES; k++) aArr[k] = b + ((k + s) % LANES) * (1 << e);
      end
      act = (pat == 3) ? 16'hFFFF : 16'($urandom);
      runReq(act, code, $urandom % 2, "R4 R6 R7 R8 R10 R11 R12 random");
    end
    done = 1;
  end

  initial begin
    wait (done || cycles > 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule